// File: doc/BRIEF.md
# Armed Triggered Sample Capture Packer

This block records a bounded burst of 16-bit converter samples in response to a trigger. Software or a sequencer first arms it with a sample count. From then on it waits for a trigger pulse. Samples that arrive before the trigger are discarded. Once the trigger has been seen, every valid sample is accepted until the configured count is reached.

Accepted samples are packed four to a 64-bit word and offered to a downstream FIFO with a one-cycle write strobe. The packing lets a 64-bit, 125 MHz data path carry the stream. The burst is finite because such a path cannot sustain many converter channels at full rate. A final word that is not full is padded with zeros. A sample that meets a full FIFO is dropped and recorded in a sticky overflow flag.

Busy covers the armed and capturing phases. Done marks a finished burst and stays high until the block is armed again.

Top module: `trig_capture_packer`

## Requirements
- R1: After reset, busy, done, overflow and wr_en are all 0.
- R2: An arm pulse seen while the block is idle or done makes busy 1 from the next cycle. It latches cap_len as the burst length and clears done and overflow. An arm pulse seen while busy has no effect, and the cap_len value presented with it is not latched.
- R3: A trigger pulse seen while the block is not armed (idle or done) is ignored: no word is written, busy stays 0, and done keeps its value.
- R4: Samples presented while armed but before the trigger are never written.
- R5: After the cycle in which the trigger is seen, each cycle with smp_valid 1 and fifo_full 0 accepts one sample. Within a word, accepted sample k (k = 0..3) occupies bits [16k+15:16k]. The first sample after the trigger lands in bits [15:0]. A full word is presented with wr_en 1 in the cycle after its fourth sample is accepted.
- R6: When the burst length is not a multiple of four, the last word carries the remaining samples in its low lanes and zeros in its unused upper lanes. It is written in the cycle after the final sample is accepted.
- R7: A valid sample that arrives while fifo_full is 1 during capture is dropped and does not count toward the length. It sets overflow, which stays 1 until the next accepted arm.
- R8: Done becomes 1 in the same cycle that the final word's wr_en is 1. At that point busy drops to 0. Done then holds until the next accepted arm.
- R9: With a latched length of zero, the trigger takes the block directly to done and no word is written.
- R10: Cycles with smp_valid 0 during capture accept nothing, so gaps between samples do not change the packed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | 16 | Converter sample |
| smp_valid | input | 1 | smp_data holds a new sample |
| arm_i | input | 1 | Arm pulse |
| trig_i | input | 1 | Trigger pulse |
| cap_len | input | 16 | Burst length in samples, latched on arm |
| fifo_full | input | 1 | Downstream FIFO cannot take data |
| wr_data | output | 64 | Packed word, lane 0 in the low bits |
| wr_en | output | 1 | Write strobe for wr_data |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Burst complete, held until the next arm |
| overflow | output | 1 | Sticky: a sample was dropped on a full FIFO |

## Verification
The packer is tested with four input patterns.

- An eight-sample burst with gaps and a stray arm in mid-capture. It must yield exactly two full words, which separates correct lane order and counting from gap- or re-arm-induced slips.
- A back-to-back six-sample burst. It exposes missing zero padding or an unwritten tail word.
- A burst with one sample offered against a full FIFO. It shows whether the dropped sample leaks into a lane or is wrongly counted.
- A zero-length burst, plus triggers and samples offered while unarmed or merely armed. These show that nothing reaches the write port outside capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ARMED   = 2'd1,
      ST_CAPTURE = 2'd2,
      ST_DONE    = 2'd3
   } cap_state_t;
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
   import cap_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             trig_i,
   input  logic             smp_valid,
   input  logic             fifo_full,
   input  logic [LEN_W-1:0] cap_len,
   output logic             accept,
   output logic             last,
   output logic             start,
   output logic             busy,
   output logic             done,
   output logic             overflow
);
   localparam int CW = LEN_W + 1;

   cap_state_t       st_q, st_d;
   logic [LEN_W-1:0] len_q, cnt_q;
   logic             ovf_q;
   logic             arm_ok, drop;
   logic [CW-1:0]    cnt_inc;

   assign arm_ok  = arm_i && (st_q == ST_IDLE || st_q == ST_DONE);
   assign start   = (st_q == ST_ARMED) && trig_i;
   assign accept  = (st_q == ST_CAPTURE) && smp_valid && !fifo_full;
   assign drop    = (st_q == ST_CAPTURE) && smp_valid && fifo_full;
   assign cnt_inc = {1'b0, cnt_q} + CW'(1);
   assign last    = accept && (cnt_inc == {1'b0, len_q});

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE, ST_DONE: if (arm_ok) st_d = ST_ARMED;
         ST_ARMED:   if (trig_i) st_d = (len_q == '0) ? ST_DONE : ST_CAPTURE;
         ST_CAPTURE: if (last) st_d = ST_DONE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         len_q <= '0;
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (arm_ok) begin
            len_q <= cap_len;
            cnt_q <= '0;
            ovf_q <= 1'b0;
         end else begin
            if (start)  cnt_q <= '0;
            if (accept) cnt_q <= cnt_inc[LEN_W-1:0];
            if (drop)   ovf_q <= 1'b1;
         end
      end
   end

   assign busy     = (st_q == ST_ARMED) || (st_q == ST_CAPTURE);
   assign done     = (st_q == ST_DONE);
   assign overflow = ovf_q;

   p_arm_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i && (st_q == ST_IDLE || st_q == ST_DONE) |=> st_q == ST_ARMED && !ovf_q);
   p_arm_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_CAPTURE && arm_i |=> $stable(len_q));
   p_trig_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_IDLE && !arm_i |=> st_q == ST_IDLE);
   p_no_accept_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(st_q) != ST_ARMED && st_q == ST_ARMED |-> cnt_q == '0);
   p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q && !arm_i |=> ovf_q);
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_DONE && !arm_i |=> st_q == ST_DONE);
   p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_ARMED && trig_i && len_q == '0 |=> st_q == ST_DONE);
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_CAPTURE |-> cnt_q < len_q);
endmodule

// File: rtl/cap_lane_pack.sv
module cap_lane_pack #(
   parameter int SAMPLE_W = 16,
   parameter int LANES    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear,
   input  logic                      accept,
   input  logic                      last,
   input  logic [SAMPLE_W-1:0]       data,
   output logic [SAMPLE_W*LANES-1:0] wr_data,
   output logic                      wr_en
);
   localparam int WORD_W = SAMPLE_W * LANES;
   localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [LW-1:0] TOP_LANE = LW'(LANES - 1);

   logic [WORD_W-1:0] acc_q, acc_nxt;
   logic [LW-1:0]     lane_q;
   logic              word_end;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign acc_nxt[i*SAMPLE_W +: SAMPLE_W] =
         (lane_q == LW'(i)) ? data : acc_q[i*SAMPLE_W +: SAMPLE_W];
   end

   assign word_end = accept && (last || lane_q == TOP_LANE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         lane_q  <= '0;
         wr_data <= '0;
         wr_en   <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (clear) begin
            acc_q  <= '0;
            lane_q <= '0;
         end else if (accept) begin
            if (word_end) begin
               wr_data <= acc_nxt;
               wr_en   <= 1'b1;
               acc_q   <= '0;
               lane_q  <= '0;
            end else begin
               acc_q  <= acc_nxt;
               lane_q <= lane_q + LW'(1);
            end
         end
      end
   end

   p_word_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      accept && last |=> wr_en);
   p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> $past(accept));
   p_gap_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !accept && !clear |=> $stable(lane_q) && !wr_en);
endmodule

// File: rtl/trig_capture_packer.sv
module trig_capture_packer #(
   parameter int SAMPLE_W = 16,
   parameter int WORD_W   = 64,
   parameter int LEN_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                smp_valid,
   input  logic                arm_i,
   input  logic                trig_i,
   input  logic [LEN_W-1:0]    cap_len,
   input  logic                fifo_full,
   output logic [WORD_W-1:0]   wr_data,
   output logic                wr_en,
   output logic                busy,
   output logic                done,
   output logic                overflow
);
   localparam int LANES = WORD_W / SAMPLE_W;

   if (WORD_W % SAMPLE_W != 0) begin : g_bad_ratio
      $error("WORD_W must be a whole multiple of SAMPLE_W");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("a word must hold at least two samples");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("LEN_W too small");
   end

   logic accept, last, start;

   cap_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (arm_i),
      .trig_i   (trig_i),
      .smp_valid(smp_valid),
      .fifo_full(fifo_full),
      .cap_len  (cap_len),
      .accept   (accept),
      .last     (last),
      .start    (start),
      .busy     (busy),
      .done     (done),
      .overflow (overflow)
   );

   cap_lane_pack #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (start),
      .accept (accept),
      .last   (last),
      .data   (smp_data),
      .wr_data(wr_data),
      .wr_en  (wr_en)
   );

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !wr_en && !busy && !done && !overflow);
   p_done_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) && $past(busy) && $past(accept) |-> wr_en);
endmodule

// File: tb/sim_trig_capture_packer.sv
`timescale 1ns/1ps
module sim_trig_capture_packer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] smp_data;
   logic        smp_valid, arm_i, trig_i, fifo_full;
   logic [15:0] cap_len;
   logic [63:0] wr_data;
   logic        wr_en, busy, done, overflow;

   int checks = 0;
   int errors = 0;
   logic [63:0] got[$];

   always #2 clk = ~clk;

   trig_capture_packer u0 (
      .clk(clk), .rst_n(rst_n), .smp_data(smp_data), .smp_valid(smp_valid),
      .arm_i(arm_i), .trig_i(trig_i), .cap_len(cap_len), .fifo_full(fifo_full),
      .wr_data(wr_data), .wr_en(wr_en), .busy(busy), .done(done), .overflow(overflow)
   );

   always @(negedge clk) if (rst_n && wr_en) got.push_back(wr_data);

   function automatic logic [63:0] pk(input logic [15:0] a, b, c, d);
      return {d, c, b, a};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_arm(input logic [15:0] len);
      @(negedge clk); arm_i = 1'b1; cap_len = len;
      @(negedge clk); arm_i = 1'b0;
   endtask

   task automatic do_trig();
      @(negedge clk); trig_i = 1'b1;
      @(negedge clk); trig_i = 1'b0;
   endtask

   task automatic smp(input logic [15:0] d, input logic full);
      @(negedge clk); smp_data = d; smp_valid = 1'b1; fifo_full = full;
      @(negedge clk); smp_valid = 1'b0; fifo_full = 1'b0;
   endtask

   task automatic burst(input int n, input logic [15:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); smp_data = base + 16'(i); smp_valid = 1'b1;
      end
      @(negedge clk); smp_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 overflow", 64'(overflow), 64'd0);
      chk("R1 wr_en", 64'(wr_en), 64'd0);
   endtask

   task automatic t_unarmed_trigger();
      got.delete();
      do_trig();
      smp(16'h1111, 1'b0);
      smp(16'h2222, 1'b0);
      idle(3);
      chk("R3 busy after stray trigger", 64'(busy), 64'd0);
      chk("R3 no words", 64'(got.size()), 64'd0);
   endtask

   task automatic t_basic_gaps();
      got.delete();
      do_arm(16'd8);
      chk("R2 busy after arm", 64'(busy), 64'd1);
      smp(16'hdead, 1'b0);
      smp(16'hbeef, 1'b0);
      chk("R4 nothing written before trigger", 64'(got.size()), 64'd0);
      do_trig();
      burst(3, 16'h0101);
      idle(2);
      do_arm(16'd3);
      smp(16'h0104, 1'b0);
      idle(1);
      chk("R5 first word", got.size() > 0 ? got[0] : 64'hx, pk(16'h0101, 16'h0102, 16'h0103, 16'h0104));
      smp(16'h0105, 1'b0);
      idle(3);
      smp(16'h0106, 1'b0);
      smp(16'h0107, 1'b0);
      smp(16'h0108, 1'b0);
      chk("R8 done with last word", 64'(done), 64'd1);
      chk("R8 busy low", 64'(busy), 64'd0);
      idle(4);
      chk("R2 R10 word count", 64'(got.size()), 64'd2);
      chk("R10 second word", got.size() > 1 ? got[1] : 64'hx, pk(16'h0105, 16'h0106, 16'h0107, 16'h0108));
      chk("R8 done holds", 64'(done), 64'd1);
   endtask

   task automatic t_partial();
      got.delete();
      do_arm(16'd6);
      chk("R2 done cleared by arm", 64'(done), 64'd0);
      do_trig();
      burst(6, 16'h0a00);
      idle(2);
      chk("R6 word count", 64'(got.size()), 64'd2);
      chk("R6 full word", got.size() > 0 ? got[0] : 64'hx, pk(16'h0a00, 16'h0a01, 16'h0a02, 16'h0a03));
      chk("R6 padded tail", got.size() > 1 ? got[1] : 64'hx, pk(16'h0a04, 16'h0a05, 16'h0, 16'h0));
   endtask

   task automatic t_overflow();
      got.delete();
      do_arm(16'd4);
      do_trig();
      smp(16'h0001, 1'b0);
      smp(16'h0002, 1'b1);
      chk("R7 overflow set", 64'(overflow), 64'd1);
      smp(16'h0003, 1'b0);
      smp(16'h0004, 1'b0);
      chk("R7 dropped not counted", 64'(done), 64'd0);
      smp(16'h0005, 1'b0);
      idle(3);
      chk("R7 word skips dropped", got.size() > 0 ? got[0] : 64'hx, pk(16'h0001, 16'h0003, 16'h0004, 16'h0005));
      chk("R7 overflow sticky", 64'(overflow), 64'd1);
      do_arm(16'd4);
      chk("R2 R7 overflow cleared by arm", 64'(overflow), 64'd0);
      do_trig();
      burst(4, 16'h0c00);
      idle(2);
      chk("R5 clean word", got.size() > 1 ? got[1] : 64'hx, pk(16'h0c00, 16'h0c01, 16'h0c02, 16'h0c03));
   endtask

   task automatic t_zero_len();
      got.delete();
      do_arm(16'd0);
      do_trig();
      chk("R9 done right after trigger", 64'(done), 64'd1);
      smp(16'h7777, 1'b0);
      idle(2);
      chk("R9 no words", 64'(got.size()), 64'd0);
   endtask

   task automatic t_trigger_in_done();
      got.delete();
      do_trig();
      smp(16'h5555, 1'b0);
      idle(2);
      chk("R3 done kept", 64'(done), 64'd1);
      chk("R3 busy low", 64'(busy), 64'd0);
      chk("R3 no words in done", 64'(got.size()), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; smp_data = '0; smp_valid = 1'b0; arm_i = 1'b0;
      trig_i = 1'b0; cap_len = '0; fifo_full = 1'b0;
      idle(4);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_unarmed_trigger();
      t_basic_gaps();
      t_partial();
      t_overflow();
      t_zero_len();
      t_trigger_in_done();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule